// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block is the host-side controller that brings a target device into its serial programming mode. When asked to start, it holds the target reset line and the serial clock low. If the power-up clock state could not be guaranteed, it can also give the reset line one short high pulse. It then waits out a configurable power-up delay and sends the four-byte programming-enable instruction. The bytes go out one at a time through a byte-wide SPI shifter, which is attached separately and drives the data pins itself.

The byte the target returns while the third instruction byte is being shifted shows whether the two sides are bit-aligned. If that echo is wrong, the sequencer still finishes all four bytes. It then inserts one extra serial clock pulse of its own to move the target's bit alignment by one position and tries again. It gives up after a fixed number of attempts. The result is shown on three flags that stay valid until the next start request.

All delays and pulse widths are counted in system clock cycles and set by parameters.

Top module: `prog_sync_seq`

## Requirements
- R1: After reset, `tgt_rst`, `seq_sck`, `shift_start`, `done`, `sync_ok` and `no_device` are all 0.
- R2: With `PULSE_EN` = 1, each session raises `tgt_rst` exactly once, for exactly `RST_PULSE_CYC` clocks, with `seq_sck` low throughout. Outside that pulse, `tgt_rst` is 0.
- R3: The first `shift_start` of a session comes exactly `PWRUP_CYC` clocks after `tgt_rst` returns low.
- R4: Each attempt sends four bytes in this order: 0xAC, 0x53, 0x00, 0x00. There is one single-cycle `shift_start` per byte, and the next byte is not issued until `shift_done` has arrived for the previous one.
- R5: The value on `shift_rx` when `shift_done` arrives for the third byte (index 2) is compared with 0x53. If it matches, `done` and `sync_ok` become 1 once the fourth byte completes, and no further byte is sent.
- R6: On a mismatch, all four bytes are still sent. The block then drives `seq_sck` high for exactly `SLIP_CYC` clocks, holds it low for `SLIP_CYC` clocks, and starts a new attempt.
- R7: After `MAX_TRIES` failed attempts (exactly 4·`MAX_TRIES` bytes), `done` and `no_device` become 1. No slip pulse follows the last attempt.
- R8: `sync_ok` and `no_device` are never both 1. The three flags hold their values until a `start_req` arrives while the block is not in a session; that request clears them in the next cycle and starts a new session. A `start_req` that arrives during a session is ignored.
- R9: `shift_start` is never high while `seq_sck` or `tgt_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Begin a new entry session |
| tgt_rst | output | 1 | Target reset line (1 = high) |
| seq_sck | output | 1 | Sequencer's contribution to the serial clock (slip pulse), ORed with the shifter's clock |
| shift_start | output | 1 | One-cycle request to the shifter to send `shift_tx` |
| shift_tx | output | 8 | Byte to transmit |
| shift_rx | input | 8 | Byte received, valid while `shift_done` is high |
| shift_done | input | 1 | Shifter has finished one byte |
| done | output | 1 | Session finished |
| sync_ok | output | 1 | Echo matched; the target is in programming mode |
| no_device | output | 1 | All attempts failed |

## Verification
On a failed echo, the cycle that judges the attempt must decide between two outcomes: insert a slip pulse, or stop because the attempt budget is used up. These two meet in the same cycle exactly when the attempt that fails is the last one allowed. The bench sweeps the number of wrong echoes from zero to past the limit, so it covers the runs that succeed on the last allowed attempt, fail on it, and stay wrong beyond it. For each run it checks the flags, the byte count and the number of slip pulses against values derived from that number. A start request is also held high across the early part of some sessions; the byte and pulse counts must stay unchanged.

// File: rtl/prog_sync_pkg.sv
package prog_sync_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOW,
      ST_PULSE,
      ST_WAIT,
      ST_ISSUE,
      ST_XFER,
      ST_JUDGE,
      ST_SLIP_HI,
      ST_SLIP_LO,
      ST_END
   } seq_state_e;

   localparam int unsigned ENABLE_LEN = 4;
   localparam int unsigned ECHO_IDX   = 2;
   localparam logic [7:0]  ECHO_EXPECT = 8'h53;

   function automatic logic [7:0] enable_byte(input logic [1:0] idx);
      case (idx)
         2'd0:    enable_byte = 8'hAC;
         2'd1:    enable_byte = 8'h53;
         default: enable_byte = 8'h00;
      endcase
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      max3 = (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pss_timer.sv
module pss_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          hit
);
   logic [TW-1:0] cnt;

   assign hit = run && (cnt == limit - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || hit)
         cnt <= '0;
      else
         cnt <= cnt + TW'(1);
   end
endmodule

// File: rtl/pss_byte_ctr.sv
module pss_byte_ctr #(
   parameter int unsigned LEN = 4,
   localparam int unsigned IW = (LEN > 1) ? $clog2(LEN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [IW-1:0] idx,
   output logic          last
);
   assign last = (idx == IW'(LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (clr)
         idx <= '0;
      else if (inc)
         idx <= last ? '0 : idx + IW'(1);
   end
endmodule

// File: rtl/pss_echo.sv
module pss_echo #(
   parameter int unsigned IW       = 2,
   parameter int unsigned CAP_IDX  = 2,
   parameter logic [7:0]  EXPECT   = 8'h53
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          strobe,
   input  logic [IW-1:0] idx,
   input  logic [7:0]    rx,
   output logic          match
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         match <= 1'b0;
      else if (clr)
         match <= 1'b0;
      else if (strobe && idx == IW'(CAP_IDX))
         match <= (rx == EXPECT);
   end
endmodule

// File: rtl/pss_tries.sv
module pss_tries #(
   parameter int unsigned MAX = 32,
   localparam int unsigned CW = $clog2(MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   logic [CW-1:0] cnt;

   assign last = (cnt == CW'(MAX - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && !last)
         cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/prog_sync_seq.sv
module prog_sync_seq
   import prog_sync_pkg::*;
#(
   parameter int unsigned PWRUP_CYC     = 2_000_000,
   parameter int unsigned RST_PULSE_CYC = 4,
   parameter int unsigned SLIP_CYC      = 4,
   parameter int unsigned MAX_TRIES     = 32,
   parameter bit          PULSE_EN      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_req,
   output logic       tgt_rst,
   output logic       seq_sck,
   output logic       shift_start,
   output logic [7:0] shift_tx,
   input  logic [7:0] shift_rx,
   input  logic       shift_done,
   output logic       done,
   output logic       sync_ok,
   output logic       no_device
);
   localparam int unsigned LONGEST = max3(PWRUP_CYC, RST_PULSE_CYC, SLIP_CYC);
   localparam int unsigned TW      = $clog2(LONGEST + 1);
   localparam int unsigned IW      = $clog2(ENABLE_LEN);

   if (PWRUP_CYC < 1)     begin : g_bad_pwrup  $error("PWRUP_CYC must be at least 1");     end
   if (RST_PULSE_CYC < 2) begin : g_bad_pulse  $error("RST_PULSE_CYC must be at least 2"); end
   if (SLIP_CYC < 1)      begin : g_bad_slip   $error("SLIP_CYC must be at least 1");      end
   if (MAX_TRIES < 1)     begin : g_bad_tries  $error("MAX_TRIES must be at least 1");     end

   seq_state_e    st, st_nx, after_low;
   logic          t_run, t_hit;
   logic [TW-1:0] t_limit;
   logic [IW-1:0] bidx;
   logic          blast;
   logic          echo_ok, tries_last;
   logic          idle_like, begin_sess, byte_fin;

   assign idle_like  = (st == ST_IDLE) || (st == ST_END);
   assign begin_sess = idle_like && start_req;
   assign byte_fin   = (st == ST_XFER) && shift_done;

   if (PULSE_EN) begin : g_pulse
      assign after_low = ST_PULSE;
      assign tgt_rst   = (st == ST_PULSE);
   end else begin : g_nopulse
      assign after_low = ST_WAIT;
      assign tgt_rst   = 1'b0;
   end

   always_comb begin
      t_run   = 1'b1;
      t_limit = TW'(1);
      case (st)
         ST_PULSE:              t_limit = TW'(RST_PULSE_CYC);
         ST_WAIT:               t_limit = TW'(PWRUP_CYC);
         ST_SLIP_HI, ST_SLIP_LO: t_limit = TW'(SLIP_CYC);
         default:               t_run   = 1'b0;
      endcase
   end

   pss_timer #(.TW(TW)) i_timer (
      .clk(clk), .rst_n(rst_n), .run(t_run), .limit(t_limit), .hit(t_hit)
   );

   pss_byte_ctr #(.LEN(ENABLE_LEN)) i_bytes (
      .clk(clk), .rst_n(rst_n),
      .clr(st == ST_LOW), .inc(byte_fin),
      .idx(bidx), .last(blast)
   );

   pss_echo #(.IW(IW), .CAP_IDX(ECHO_IDX), .EXPECT(ECHO_EXPECT)) i_echo (
      .clk(clk), .rst_n(rst_n),
      .clr(st == ST_LOW), .strobe(byte_fin),
      .idx(bidx), .rx(shift_rx), .match(echo_ok)
   );

   pss_tries #(.MAX(MAX_TRIES)) i_tries (
      .clk(clk), .rst_n(rst_n),
      .clr(st == ST_LOW), .inc((st == ST_JUDGE) && !echo_ok),
      .last(tries_last)
   );

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE, ST_END: if (start_req) st_nx = ST_LOW;
         ST_LOW:          st_nx = after_low;
         ST_PULSE:        if (t_hit) st_nx = ST_WAIT;
         ST_WAIT:         if (t_hit) st_nx = ST_ISSUE;
         ST_ISSUE:        st_nx = ST_XFER;
         ST_XFER:         if (shift_done) st_nx = blast ? ST_JUDGE : ST_ISSUE;
         ST_JUDGE:        st_nx = (echo_ok || tries_last) ? ST_END : ST_SLIP_HI;
         ST_SLIP_HI:      if (t_hit) st_nx = ST_SLIP_LO;
         ST_SLIP_LO:      if (t_hit) st_nx = ST_ISSUE;
         default:         st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= ST_IDLE;
      else
         st <= st_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         sync_ok   <= 1'b0;
         no_device <= 1'b0;
      end else if (begin_sess) begin
         done      <= 1'b0;
         sync_ok   <= 1'b0;
         no_device <= 1'b0;
      end else if (st == ST_JUDGE) begin
         done      <= echo_ok || tries_last;
         sync_ok   <= echo_ok;
         no_device <= !echo_ok && tries_last;
      end
   end

   assign seq_sck     = (st == ST_SLIP_HI);
   assign shift_start = (st == ST_ISSUE);
   assign shift_tx    = enable_byte(bidx);

endmodule

// File: rtl/prog_sync_seq_chk.sv
module prog_sync_seq_chk
   import prog_sync_pkg::*;
#(
   parameter int unsigned MAX_TRIES = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_req,
   input logic       tgt_rst,
   input logic       seq_sck,
   input logic       shift_start,
   input logic       done,
   input logic       sync_ok,
   input logic       no_device,
   input seq_state_e st
);
   localparam int unsigned NW = $clog2(4 * MAX_TRIES + 1) + 1;
   logic [NW-1:0] n_starts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         n_starts <= '0;
      else if (st == ST_LOW)
         n_starts <= '0;
      else if (shift_start)
         n_starts <= n_starts + NW'(1);
   end

   p_rst_sck_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rst |-> !seq_sck);

   p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_start |=> !shift_start);

   p_sync_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_ok) |-> (n_starts[1:0] == 2'b00) && (n_starts != '0));

   p_nodev_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(no_device) |-> (n_starts == NW'(4 * MAX_TRIES)));

   p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sync_ok, no_device}));

   p_flags_need_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok || no_device) |-> done);

   p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start_req) |=> $stable({done, sync_ok, no_device}));

   p_start_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      shift_start |-> (!seq_sck && !tgt_rst));

endmodule

bind prog_sync_seq prog_sync_seq_chk #(.MAX_TRIES(MAX_TRIES)) i_chk (
   .clk(clk), .rst_n(rst_n), .start_req(start_req), .tgt_rst(tgt_rst),
   .seq_sck(seq_sck), .shift_start(shift_start), .done(done),
   .sync_ok(sync_ok), .no_device(no_device), .st(st)
);

// File: tb/test_prog_sync_seq.sv
`timescale 1ns/1ps
module test_prog_sync_seq;
   localparam int PW = 20;
   localparam int RP = 3;
   localparam int SL = 2;
   localparam int MT = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_req = 1'b0;
   logic       tgt_rst, seq_sck, shift_start;
   logic [7:0] shift_tx;
   logic [7:0] shift_rx = 8'h00;
   logic       shift_done = 1'b0;
   logic       done, sync_ok, no_device;

   always #2.5 clk = ~clk;

   prog_sync_seq #(
      .PWRUP_CYC(PW), .RST_PULSE_CYC(RP), .SLIP_CYC(SL),
      .MAX_TRIES(MT), .PULSE_EN(1'b1)
   ) i_prog_sync_seq (
      .clk(clk), .rst_n(rst_n), .start_req(start_req),
      .tgt_rst(tgt_rst), .seq_sck(seq_sck),
      .shift_start(shift_start), .shift_tx(shift_tx),
      .shift_rx(shift_rx), .shift_done(shift_done),
      .done(done), .sync_ok(sync_ok), .no_device(no_device)
   );

   int tests = 0, fails = 0;
   bit finished = 0;

   // shifter model state
   int k_good = 0, lat = 1, att = 0, bidx = 0, n_bytes = 0, tx_bad = 0;
   // monitor state
   int n_starts_all = 0, slips = 0, slip_bad = 0, rst_pulses = 0, rst_bad = 0;
   int hi_run = 0, rst_run = 0, gap = 0, gap_bad = 0;
   bit gap_open = 0;

   function automatic logic [7:0] want_byte(input int i);
      case (i)
         0: return 8'hAC;
         1: return 8'h53;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // byte shifter model
   initial begin
      forever begin
         @(negedge clk);
         shift_done = 1'b0;
         if (shift_start) begin
            if (shift_tx !== want_byte(bidx)) tx_bad++;
            n_bytes++;
            repeat (lat) @(negedge clk);
            shift_rx   = (bidx == 2) ? ((att >= k_good) ? 8'h53 : 8'hA6) : 8'h5A;
            shift_done = 1'b1;
            if (bidx == 3) begin bidx = 0; att++; end
            else bidx++;
         end
      end
   end

   // line monitor
   initial begin
      forever begin
         @(negedge clk);
         if (shift_start) begin
            n_starts_all++;
            if (gap_open) begin
               if (gap != PW) gap_bad++;
               gap_open = 0;
            end
         end
         if (gap_open) gap++;
         if (seq_sck) hi_run++;
         else if (hi_run > 0) begin
            slips++;
            if (hi_run != SL) slip_bad++;
            hi_run = 0;
         end
         if (tgt_rst) begin
            rst_run++;
            if (seq_sck) rst_bad++;
         end else if (rst_run > 0) begin
            rst_pulses++;
            if (rst_run != RP) rst_bad++;
            rst_run = 0;
            gap_open = 1;
            gap = 1;
         end
      end
   end

   task automatic run_session(input int k, input int l, input bit hold);
      int ea;
      bit exp_ok;
      k_good = k; lat = l; att = 0; bidx = 0; n_bytes = 0; tx_bad = 0;
      n_starts_all = 0; slips = 0; slip_bad = 0; rst_pulses = 0; rst_bad = 0;
      gap_bad = 0;
      @(negedge clk);
      start_req = 1'b1;
      @(negedge clk);
      if (!hold) start_req = 1'b0;
      chk(done == 1'b0 && sync_ok == 1'b0 && no_device == 1'b0, "R8 flags cleared on start",
          {done, sync_ok, no_device}, 0);
      if (hold) begin
         repeat (30) @(negedge clk);
         start_req = 1'b0;
      end
      while (!done) @(negedge clk);
      repeat (12) @(negedge clk);
      ea     = (k < MT) ? k + 1 : MT;
      exp_ok = (k < MT);
      chk(sync_ok == exp_ok, "R5 sync_ok", sync_ok, exp_ok);
      chk(no_device == !exp_ok, "R7 no_device", no_device, !exp_ok);
      chk(done == 1'b1, "R8 done held", done, 1);
      chk(n_bytes == 4 * ea, "R4 byte count", n_bytes, 4 * ea);
      chk(n_starts_all == n_bytes, "R9 start only when shifter idle", n_starts_all, n_bytes);
      chk(tx_bad == 0, "R4 byte order", tx_bad, 0);
      chk(slips == ea - 1, "R6 R7 slip pulses", slips, ea - 1);
      chk(slip_bad == 0, "R6 slip width", slip_bad, 0);
      chk(rst_pulses == 1 && rst_bad == 0, "R2 reset pulse", rst_pulses * 100 + rst_bad, 100);
      chk(gap_bad == 0, "R3 power-up delay", gap_bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({tgt_rst, seq_sck, shift_start, done, sync_ok, no_device} == 6'b0,
          "R1 reset state", {tgt_rst, seq_sck, shift_start, done, sync_ok, no_device}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({tgt_rst, seq_sck, shift_start, done} == 4'b0, "R1 idle after reset",
          {tgt_rst, seq_sck, shift_start, done}, 0);
      for (int k = 0; k <= MT + 1; k++)
         run_session(k, 1 + (k % 3), k[0]);
      // flags stay after many idle cycles
      repeat (50) @(negedge clk);
      chk(done == 1'b1 && no_device == 1'b1 && sync_ok == 1'b0, "R8 flags held idle",
          {done, sync_ok, no_device}, 5);
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule